// File: doc/BRIEF.md
# Receive Descriptor Search Engine

This block locates the next receive buffer that hardware may fill, inside a ring of descriptors kept in system memory. A search is started with a start address and a required buffer size. The engine reads descriptors one at a time through a read-request/read-response memory port. It stops at the first descriptor that hardware owns and whose buffer is large enough. If it gets back to where it began, or the chain breaks, no buffer is available.

Each descriptor is four 32-bit words at consecutive byte offsets 0, 4, 8 and 12. Word 0 holds the ownership flag. Word 1 holds the buffer length. Word 3 holds the address of the following descriptor. Word 2, the buffer pointer, is not read.

The engine keeps the current receive pointer and a sticky buffer-unavailable status bit. The status bit is gated by an enable input to form the interrupt.

A frame that needs another buffer can use a continuation request. This request starts at the link of the descriptor last matched and uses the minimum frame size.

Both the request port and the memory request port follow valid/ready rules. A request is taken on a cycle where valid and ready are both high. The requester must keep valid and its payload steady until that cycle.

Top module: `rx_desc_seek`

## Requirements
- R1: A descriptor matches when bit 31 of word 0 (ownership) is 1 and bits 10:0 of word 1 (buffer length) are greater than or equal to the requested minimum. The search returns the address of the first match, in link order from the start address.
- R2: A requested minimum of zero disables the length test, so only ownership decides a match. A length of zero then still matches.
- R3: With `req_advance` set, the search starts at word 3 of the descriptor that matched most recently. The minimum is the `FRAME_MIN` parameter (64), and the request's address and size inputs are ignored.
- R4: If a descriptor does not match and its word 3 equals the start address of the search, the search ends with not-found.
- R5: A start address of zero ends the search with not-found and no memory read. A non-matching descriptor whose word 3 is zero also ends the search with not-found.
- R6: When a search ends, `cur_ptr` becomes the matched address, or zero on not-found. A not-found result sets `unavail_sts`, which stays set until an `unavail_clr` pulse. A found result leaves it unchanged.
- R7: `irq` is high exactly when `unavail_sts` and `irq_en` are both high.
- R8: A search that has read `MAX_VISITS` (256) descriptors without a match or a ring end stops with not-found, even on a ring that never returns to its start.
- R9: For each descriptor, the engine reads words 0, 1 and 3, at byte offsets 0, 4 and 12, in that order. It has at most one read outstanding. A request that is not accepted keeps its address until it is.
- R10: `done_valid` is a single-cycle pulse at the end of each search. `req_ready` is high only while no search is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Search request valid |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_advance | input | 1 | Continue from last match's link with minimum 64 |
| req_start_addr | input | ADDR_W | First descriptor address |
| req_min_size | input | SIZE_W | Required buffer length, 0 = any |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Byte address of word read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine waits for read data |
| mem_rsp_data | input | DATA_W | Read data |
| done_valid | output | 1 | Search finished (one cycle) |
| done_found | output | 1 | A usable descriptor was found |
| done_addr | output | ADDR_W | Matching descriptor address, 0 if none |
| cur_ptr | output | ADDR_W | Current receive pointer |
| unavail_sts | output | 1 | Sticky buffer-unavailable status |
| unavail_clr | input | 1 | Clears the status bit |
| irq_en | input | 1 | Interrupt enable for the status bit |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. These are the memory-port handshake: requests held while stalled, and no new request while data is awaited. The single-cycle done pulse and its exclusion from idle are also checked, along with how the pointer and status agree with each result, the interrupt gating, and a bound on reads per search. Which descriptor is chosen, the wrap at the start address, the effect of a zero minimum, and continuation from the last link only show against the bench's reference walk. The same holds for the exact read count, and for the 256-visit cut-off on a ring that loops without its head. The bench shows these over swept ring contents, start points and minimum sizes.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int WORD_BYTES = 4;
  localparam int OWN_BIT    = 31;
  localparam int LEN_W      = 11;
  localparam int LINK_WORD  = 3;
  localparam int NUM_SLOTS  = 3;

  typedef enum logic [1:0] {
    SEEK_IDLE,
    SEEK_WALK,
    SEEK_DONE
  } seek_state_e;

  function automatic int slot_word(input int slot);
    return (slot == NUM_SLOTS - 1) ? LINK_WORD : slot;
  endfunction
endpackage

// File: rtl/rxs_desc_fetch.sv
module rxs_desc_fetch
  import rxs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [DATA_W-1:0] word_stat,
  output logic [DATA_W-1:0] word_len,
  output logic [DATA_W-1:0] word_link
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic              busy_q, issued_q, done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] slot_q [NUM_SLOTS];
  logic              rsp_take;
  int                word_off;

  assign mem_req_valid = busy_q && !issued_q;
  assign mem_rsp_ready = busy_q && issued_q;
  assign rsp_take      = mem_rsp_ready && mem_rsp_valid;
  assign word_off      = slot_word(int'(idx_q)) * WORD_BYTES;
  assign mem_req_addr  = base_q + ADDR_W'(word_off);
  assign done          = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        busy_q   <= 1'b1;
        issued_q <= 1'b0;
        idx_q    <= '0;
        base_q   <= base;
      end else if (busy_q) begin
        if (mem_req_valid && mem_req_ready) issued_q <= 1'b1;
        if (rsp_take) begin
          issued_q <= 1'b0;
          if (idx_q == IDX_W'(NUM_SLOTS - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[k] <= '0;
      else if (rsp_take && idx_q == IDX_W'(k)) slot_q[k] <= mem_rsp_data;
    end
  end

  assign word_stat = slot_q[0];
  assign word_len  = slot_q[1];
  assign word_link = slot_q[NUM_SLOTS-1];
endmodule

// File: rtl/rxs_match.sv
module rxs_match
  import rxs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 11
) (
  input  logic [DATA_W-1:0] word_stat,
  input  logic [DATA_W-1:0] word_len,
  input  logic [SIZE_W-1:0] min_size,
  output logic              hit
);
  logic              owned;
  logic [LEN_W-1:0]  buf_len;
  logic              len_ok;
  logic              unused_bits;

  assign owned       = word_stat[OWN_BIT];
  assign buf_len     = word_len[LEN_W-1:0];
  assign len_ok      = (min_size == '0) || ({{(SIZE_W > LEN_W ? SIZE_W - LEN_W : 0){1'b0}}, buf_len} >= min_size);
  assign hit         = owned && len_ok;
  assign unused_bits = ^{word_stat, word_len};
endmodule

// File: rtl/rxs_irq_status.sv
module rxs_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic sts,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sts <= 1'b0;
    else if (set) sts <= 1'b1;
    else if (clr) sts <= 1'b0;
  end

  assign irq = sts & en;
endmodule

// File: rtl/rx_desc_seek.sv
module rx_desc_seek
  import rxs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SIZE_W     = 11,
  parameter int MAX_VISITS = 256,
  parameter int FRAME_MIN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_advance,
  input  logic [ADDR_W-1:0] req_start_addr,
  input  logic [SIZE_W-1:0] req_min_size,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              done_valid,
  output logic              done_found,
  output logic [ADDR_W-1:0] done_addr,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              unavail_sts,
  input  logic              unavail_clr,
  input  logic              irq_en,
  output logic              irq
);
  localparam int VIS_W = $clog2(MAX_VISITS + 1);

  seek_state_e       state_q;
  logic [ADDR_W-1:0] start_q, walk_q, res_q, ptr_q, last_link_q;
  logic [SIZE_W-1:0] min_q;
  logic [VIS_W-1:0]  visits_q;
  logic              found_q;

  logic              accept, fetch_go, fetch_done, hit, end_miss, set_unavail;
  logic [ADDR_W-1:0] start_eff, fetch_base, link_addr;
  logic [SIZE_W-1:0] min_eff;
  logic [DATA_W-1:0] w_stat, w_len, w_link;

  assign req_ready  = (state_q == SEEK_IDLE);
  assign accept     = req_ready && req_valid;
  assign start_eff  = req_advance ? last_link_q : req_start_addr;
  assign min_eff    = req_advance ? SIZE_W'(FRAME_MIN) : req_min_size;
  assign link_addr  = w_link[ADDR_W-1:0];
  assign end_miss   = (link_addr == start_q) || (link_addr == '0) ||
                      (visits_q + 1'b1 == VIS_W'(MAX_VISITS));

  always_comb begin
    fetch_go    = 1'b0;
    fetch_base  = start_eff;
    set_unavail = 1'b0;
    if (state_q == SEEK_IDLE && accept) begin
      fetch_go    = (start_eff != '0);
      set_unavail = (start_eff == '0);
    end else if (state_q == SEEK_WALK && fetch_done && !hit) begin
      fetch_go    = !end_miss;
      fetch_base  = link_addr;
      set_unavail = end_miss;
    end
  end

  rxs_desc_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk, .rst_n, .go(fetch_go), .base(fetch_base),
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .done(fetch_done), .word_stat(w_stat), .word_len(w_len), .word_link(w_link)
  );

  rxs_match #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_match (
    .word_stat(w_stat), .word_len(w_len), .min_size(min_q), .hit
  );

  rxs_irq_status u_sts (
    .clk, .rst_n, .set(set_unavail), .clr(unavail_clr), .en(irq_en),
    .sts(unavail_sts), .irq
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SEEK_IDLE;
      start_q     <= '0;
      walk_q      <= '0;
      res_q       <= '0;
      ptr_q       <= '0;
      last_link_q <= '0;
      min_q       <= '0;
      visits_q    <= '0;
      found_q     <= 1'b0;
    end else begin
      unique case (state_q)
        SEEK_IDLE: if (accept) begin
          start_q  <= start_eff;
          walk_q   <= start_eff;
          min_q    <= min_eff;
          visits_q <= '0;
          if (start_eff == '0) begin
            found_q <= 1'b0;
            res_q   <= '0;
            ptr_q   <= '0;
            state_q <= SEEK_DONE;
          end else begin
            state_q <= SEEK_WALK;
          end
        end
        SEEK_WALK: if (fetch_done) begin
          visits_q <= visits_q + 1'b1;
          if (hit) begin
            found_q     <= 1'b1;
            res_q       <= walk_q;
            ptr_q       <= walk_q;
            last_link_q <= link_addr;
            state_q     <= SEEK_DONE;
          end else if (end_miss) begin
            found_q <= 1'b0;
            res_q   <= '0;
            ptr_q   <= '0;
            state_q <= SEEK_DONE;
          end else begin
            walk_q <= link_addr;
          end
        end
        default: state_q <= SEEK_IDLE;
      endcase
    end
  end

  assign done_valid = (state_q == SEEK_DONE);
  assign done_found = found_q;
  assign done_addr  = res_q;
  assign cur_ptr    = ptr_q;
endmodule

// File: rtl/rxs_seek_chk.sv
module rxs_seek_chk #(
  parameter int ADDR_W     = 32,
  parameter int MAX_VISITS = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_ready,
  input logic              done_valid,
  input logic              done_found,
  input logic [ADDR_W-1:0] done_addr,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic              unavail_sts,
  input logic              unavail_clr,
  input logic              irq_en,
  input logic              irq
);
  int unsigned reads_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      reads_q <= 0;
    else if (req_valid && req_ready) reads_q <= 0;
    else if (mem_req_valid && mem_req_ready) reads_q <= reads_q + 1;
  end

  assert_found_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_found |-> (cur_ptr == done_addr) && (done_addr != '0));

  assert_miss_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_found |-> (cur_ptr == '0) && unavail_sts);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unavail_sts && !unavail_clr |=> unavail_sts);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> unavail_sts && irq_en);

  assert_read_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reads_q <= 3 * MAX_VISITS);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && done_valid));
endmodule

bind rx_desc_seek rxs_seek_chk #(.ADDR_W(ADDR_W), .MAX_VISITS(MAX_VISITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_ready(mem_rsp_ready),
  .done_valid(done_valid), .done_found(done_found), .done_addr(done_addr),
  .cur_ptr(cur_ptr), .unavail_sts(unavail_sts), .unavail_clr(unavail_clr),
  .irq_en(irq_en), .irq(irq)
);

// File: tb/test_rx_desc_seek.sv
module test_rx_desc_seek;
  localparam int MAXV = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_advance = 1'b0;
  logic        req_ready;
  logic [31:0] req_start_addr = '0;
  logic [10:0] req_min_size = '0;
  logic        mem_req_valid, mem_rsp_ready;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_rsp_data = '0;
  logic        done_valid, done_found, unavail_sts, irq;
  logic [31:0] done_addr, cur_ptr;
  logic        unavail_clr = 1'b0, irq_en = 1'b0;

  logic [31:0] mem [0:127];
  int          errors = 0, checks = 0, cyc = 0, rd_seen = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  bit          exp_sts = 0;
  logic [31:0] last_link = '0;

  always #4 clk = ~clk;

  rx_desc_seek i_rx_desc_seek (
    .clk, .rst_n, .req_valid, .req_ready, .req_advance, .req_start_addr,
    .req_min_size, .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data, .done_valid, .done_found,
    .done_addr, .cur_ptr, .unavail_sts, .unavail_clr, .irq_en, .irq
  );

  // memory model: stalls on requests and delays responses
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 5) != 2;
    if (mem_req_valid && mem_req_ready) begin
      pend      <= 1'b1;
      pend_addr <= mem_req_addr;
      rd_seen   <= rd_seen + 1;
    end
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    else if (pend && !mem_rsp_valid && (cyc % 3) != 1) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[pend_addr[8:2]];
      pend          <= 1'b0;
    end
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual cyc=%0d expected < 190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dbase(input int i);
    return 32'h10 * (i + 1);
  endfunction

  task automatic put_desc(input logic [31:0] a, input bit own, input int len,
                          input logic [31:0] link);
    mem[a[8:2]]     = {own, 31'h0};
    mem[a[8:2] + 1] = 32'hFFFF_F800 | 32'(len);
    mem[a[8:2] + 2] = 32'hBEEF_0000 | a;
    mem[a[8:2] + 3] = link;
  endtask

  task automatic build_ring(input int p);
    for (int i = 0; i < 8; i++)
      put_desc(dbase(i), (p != 4) && (((i + p) % 3) != 0),
               (i * 211 + p * 389 + 40) % 2048, dbase((i + 1) % 8));
  endtask

  // reference walk from the requirements
  task automatic model(input logic [31:0] start, input int minsz,
                       output bit f, output logic [31:0] a, output int visits);
    logic [31:0] cur;
    cur = start; f = 0; a = '0; visits = 0;
    if (start == '0) return;
    forever begin
      logic [31:0] w0, w1, w3;
      w0 = mem[cur[8:2]]; w1 = mem[cur[8:2] + 1]; w3 = mem[cur[8:2] + 3];
      visits++;
      if (w0[31] && (minsz == 0 || int'(w1[10:0]) >= minsz)) begin
        f = 1; a = cur; return;
      end
      if (w3 == start || w3 == '0 || visits == MAXV) return;
      cur = w3;
    end
  endtask

  task automatic run(input bit adv, input logic [31:0] start, input int minsz,
                     input string tag);
    bit f; logic [31:0] a; int v, n, r0;
    model(adv ? last_link : start, adv ? 64 : minsz, f, a, v);
    @(negedge clk);
    r0 = rd_seen;
    req_valid = 1'b1; req_advance = adv;
    req_start_addr = start; req_min_size = 11'(minsz);
    @(negedge clk);
    req_valid = 1'b0; req_advance = 1'b0;
    n = 0;
    while (!done_valid && n < 20000) begin @(negedge clk); n++; end
    check(done_valid, "R10", {tag, " done seen"}, 32'(done_valid), 1);
    check(done_found == f, f ? "R1" : "R4", {tag, " found"}, 32'(done_found), 32'(f));
    check(done_addr == a, "R1", {tag, " addr"}, done_addr, a);
    check(cur_ptr == a, "R6", {tag, " cur_ptr"}, cur_ptr, a);
    check(rd_seen - r0 == 3 * v, "R9", {tag, " reads"}, 32'(rd_seen - r0), 32'(3 * v));
    if (!f) exp_sts = 1;
    else last_link = mem[a[8:2] + 3];
    check(unavail_sts == exp_sts, "R6", {tag, " status"}, 32'(unavail_sts), 32'(exp_sts));
    @(negedge clk);
    check(!done_valid && req_ready, "R10", {tag, " pulse end"},
          {30'h0, done_valid, req_ready}, 32'h1);
  endtask

  task automatic clear_sts();
    @(negedge clk); unavail_clr = 1'b1;
    @(negedge clk); unavail_clr = 1'b0;
    exp_sts = 0;
  endtask

  initial begin
    int mins [4] = '{0, 64, 300, 1500};
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done_valid && !mem_req_valid && cur_ptr == 0 && !unavail_sts && !irq,
          "R10", "reset state", {26'h0, req_ready, done_valid, mem_req_valid, unavail_sts, irq, 1'b0},
          32'h20);

    // sweep ring contents, start points and minimum sizes (R1, R4)
    for (int p = 0; p < 5; p++) begin
      build_ring(p);
      for (int s = 0; s < 8; s++)
        for (int m = 0; m < 4; m++) begin
          run(0, dbase(s), mins[m], "sweep");
          if (done_found) run(1, 32'h0, 0, "R3 advance");
        end
    end
    clear_sts();

    // zero minimum: owned zero-length descriptor (R2)
    build_ring(4);
    put_desc(dbase(2), 1, 0, dbase(3));
    put_desc(dbase(5), 1, 700, dbase(6));
    run(0, dbase(0), 0, "R2 min zero");
    run(0, dbase(0), 1, "R2 min one");
    check(done_addr == dbase(5), "R2", "len test skips", done_addr, dbase(5));

    // advance ignores address and size inputs (R3)
    run(0, dbase(2), 0, "R3 seed");
    run(1, dbase(7), 1500, "R3 inputs ignored");
    check(done_addr == dbase(5), "R3", "continuation target", done_addr, dbase(5));
    clear_sts();

    // zero start and zero link (R5)
    run(0, 32'h0, 0, "R5 zero start");
    put_desc(32'hC0, 0, 100, 32'h0);
    run(0, 32'hC0, 0, "R5 zero link");

    // ring that never returns to its head (R8)
    put_desc(32'h90, 0, 100, 32'hA0);
    put_desc(32'hA0, 0, 100, 32'hB0);
    put_desc(32'hB0, 0, 100, 32'hA0);
    run(0, 32'h90, 0, "R8 visit limit");

    // interrupt gating and clear (R7)
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    check(unavail_sts && !irq, "R7", "masked", 32'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq, "R7", "enabled", 32'(irq), 1);
    clear_sts();
    @(negedge clk);
    check(!unavail_sts && !irq, "R7", "cleared", {30'h0, unavail_sts, irq}, 0);
    run(0, dbase(0), 0, "R6 found keeps clear");
    check(!irq, "R7", "no irq after find", 32'(irq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule